// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block collects 32 level-sensitive interrupt requests and turns them into two processor interrupt lines: a fast line and a normal line. Each line has its own enable mask. A source can be routed to the fast line, to the normal line, to both or to neither. The block captures the request levels into a raw status word and ANDs that word with each mask to form two masked status words. Each output line is high while its masked word has any bit set.

Software changes the masks only through atomic bit operations. One register per mask ORs the written data into that mask. A second register per mask clears the bits where the written data has ones. The two clear registers always read as zero. A single-cycle register port gives access to the raw word, both masked words and both masks. Only full-word accesses act on the block. Byte and halfword accesses return zero and change nothing.

Top module: `dual_irq_ctrl`

## Requirements
- R1: The raw status word (read offset 0x00) equals the request input vector as sampled at the previous rising clock edge. Bit n follows input n.
- R2: The fast status word (offset 0x04) equals the raw word ANDed with the fast mask. The normal status word (offset 0x08) equals the raw word ANDed with the normal mask.
- R3: `fiq_o` is high exactly while the fast status word is nonzero. It changes in the same cycle as that word.
- R4: `irq_o` is high exactly while the normal status word is nonzero. It changes in the same cycle as that word.
- R5: A full-word write to 0x0C ORs the write data into the fast mask. A full-word write to 0x10 ORs the write data into the normal mask. Both masks read back at those same offsets.
- R6: A full-word write to 0x14 clears the fast mask bits where the data is 1. A full-word write to 0x18 does the same for the normal mask. Reads of 0x14 and 0x18 return zero.
- R7: Access size is coded on `bus_size`: 2'b00 is byte, 2'b01 is halfword, 2'b10 is word. Only the word code (2'b10) takes effect. Any other size reads zero and its writes change no mask.
- R8: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 return zero, even when the address is misaligned. Writes to any offset other than the four mask registers change nothing, including writes to the read-only status offsets.
- R9: After a clock edge with `rst_n` low, the raw word, both masks, both masked words and both outputs are zero.
- R10: When `bus_en` is low, `bus_rdata` is zero and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 32 | Level requests, synchronous to clk |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 word |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| fiq_o | output | 1 | Fast interrupt line |
| irq_o | output | 1 | Normal interrupt line |

## Verification
A corrupted mask bit shows up on the next read of that mask and of its masked status word. It also shows as a wrong level on the matching output line, one cycle after the request or write that exposes the bit. An output register that drifts from its status word is visible in the same cycle that word changes. Every write and every request change is therefore followed at once by a full readback of all seven offsets and both lines. This compares the state against a model kept in the bench.

// File: rtl/dual_irq_ctrl_pkg.sv
// Shared constants for the dual-output interrupt controller.
// Assumes byte offsets on an 8-bit register address.
package dual_irq_ctrl_pkg;
    localparam int SRC_N  = 32;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } acc_size_e;

    localparam logic [ADDR_W-1:0] OFS_RAW      = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_FAST_ST  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_NORM_ST  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_FAST_SET = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_NORM_SET = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FAST_CLR = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_NORM_CLR = 8'h18;
endpackage

// File: rtl/dual_irq_raw_capture.sv
// Registers the request levels into the raw status word.
// Assumes the requests are already synchronous to clk.
module dual_irq_raw_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_i,
    output logic [W-1:0] raw_o
);
    // Capture the request levels every cycle; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_o <= '0;
        else        raw_o <= req_i;
    end

    // R1
    raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> raw_o == $past(req_i));
endmodule

// File: rtl/dual_irq_mask_lane.sv
// One output lane: an enable mask changed by set and clear strobes,
// plus a registered line output. The line is computed from the next
// raw and mask values, so it changes in the same cycle as the status word.
// Assumes set and clear are never strobed in the same cycle.
module dual_irq_mask_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] raw_next,
    input  logic [W-1:0] raw_q,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] status_o,
    output logic         line_o
);
    logic [W-1:0] mask_d;

    // Apply the set or clear strobe to form the next mask.
    always_comb begin
        mask_d = mask_o;
        if (set_stb) mask_d = mask_o | wdata;
        if (clr_stb) mask_d = mask_o & ~wdata;
    end

    // Hold the mask and the line output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
            line_o <= 1'b0;
        end else begin
            mask_o <= mask_d;
            line_o <= |(raw_next & mask_d);
        end
    end

    // Form the masked status word.
    always_comb status_o = raw_q & mask_o;

    // R3
    line_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_o == (|(raw_q & mask_o)));
    // R5
    set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((mask_o & $past(wdata)) == $past(wdata)));
    // R6
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((mask_o & $past(wdata)) == '0));
    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(mask_o));
endmodule

// File: rtl/dual_irq_ctrl.sv
// Dual-output interrupt controller. It decodes the register port,
// instantiates the raw capture and two mask lanes (fast and normal),
// and returns read data. Only word-size accesses take effect.
module dual_irq_ctrl
    import dual_irq_ctrl_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    output logic          fiq_o,
    output logic          irq_o
);
    localparam int LANES = 2;

    logic          word_acc;
    logic          wr_ok;
    logic [N-1:0]  raw_q;
    logic [N-1:0]  mask   [LANES];
    logic [N-1:0]  status [LANES];
    logic [LANES-1:0] line;
    logic [LANES-1:0] set_stb;
    logic [LANES-1:0] clr_stb;

    // Qualify the access: strobe high and word size.
    always_comb begin
        word_acc = bus_en && (bus_size == SZ_WORD);
        wr_ok    = word_acc && bus_we;
    end

    dual_irq_raw_capture #(.W(N)) u_raw (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .raw_o (raw_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [AW-1:0] SET_OFS = (g == 0) ? OFS_FAST_SET : OFS_NORM_SET;
        localparam logic [AW-1:0] CLR_OFS = (g == 0) ? OFS_FAST_CLR : OFS_NORM_CLR;

        // Decode the set and clear strobes for this lane.
        always_comb begin
            set_stb[g] = wr_ok && (bus_addr == SET_OFS);
            clr_stb[g] = wr_ok && (bus_addr == CLR_OFS);
        end

        dual_irq_mask_lane #(.W(N)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_stb  (set_stb[g]),
            .clr_stb  (clr_stb[g]),
            .wdata    (bus_wdata),
            .raw_next (req_i),
            .raw_q    (raw_q),
            .mask_o   (mask[g]),
            .status_o (status[g]),
            .line_o   (line[g])
        );
    end

    assign fiq_o = line[0];
    assign irq_o = line[1];

    // Select read data; anything but a word read of a readable offset is zero.
    always_comb begin
        bus_rdata = '0;
        if (word_acc && !bus_we) begin
            unique case (bus_addr)
                OFS_RAW:      bus_rdata = raw_q;
                OFS_FAST_ST:  bus_rdata = status[0];
                OFS_NORM_ST:  bus_rdata = status[1];
                OFS_FAST_SET: bus_rdata = mask[0];
                OFS_NORM_SET: bus_rdata = mask[1];
                default:      bus_rdata = '0;
            endcase
        end
    end

    // R7
    narrow_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_size != SZ_WORD) |-> bus_rdata == '0);
    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> bus_rdata == '0);
    // R4
    irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|status[1]));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!fiq_o && !irq_o && raw_q == '0));
endmodule

// File: tb/dual_irq_ctrl_test.sv
// Table-driven bench with a separate model, followed by directed cases.
module dual_irq_ctrl_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_i = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fiq_o, irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] m_raw = '0, m_fm = '0, m_nm = '0;

    dual_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_en(bus_en),
        .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fiq_o(fiq_o), .irq_o(irq_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // Vector: kind(0 req,1 write) size addr data
    localparam int NV = 16;
    localparam logic [43:0] VEC [NV] = '{
        {2'd1, 2'b10, 8'h0C, 32'h0000_00F0},
        {2'd1, 2'b10, 8'h10, 32'h0000_0F0F},
        {2'd0, 2'b10, 8'h00, 32'h0000_0010},
        {2'd0, 2'b10, 8'h00, 32'h0000_0100},
        {2'd0, 2'b10, 8'h00, 32'h8000_0003},
        {2'd1, 2'b10, 8'h0C, 32'h8000_0000},
        {2'd1, 2'b10, 8'h18, 32'h0000_0003},
        {2'd1, 2'b10, 8'h10, 32'h0000_0001},
        {2'd1, 2'b00, 8'h0C, 32'hFFFF_FFFF},
        {2'd1, 2'b01, 8'h10, 32'hFFFF_FFFF},
        {2'd1, 2'b10, 8'h00, 32'hFFFF_FFFF},
        {2'd1, 2'b10, 8'h0D, 32'hFFFF_FFFF},
        {2'd1, 2'b10, 8'h14, 32'h8000_0000},
        {2'd0, 2'b10, 8'h00, 32'h5A5A_0000},
        {2'd1, 2'b10, 8'h14, 32'hFFFF_FFFF},
        {2'd0, 2'b10, 8'h00, 32'hFFFF_FFFF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        #1 d = bus_rdata;
        bus_en = 1'b0; bus_size = 2'b10;
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_size = 2'b10;
        if (sz == 2'b10) begin
            case (a)
                8'h0C: m_fm = m_fm | d;
                8'h10: m_nm = m_nm | d;
                8'h14: m_fm = m_fm & ~d;
                8'h18: m_nm = m_nm & ~d;
                default: ;
            endcase
        end
    endtask

    task automatic drive_req(input logic [31:0] v);
        @(negedge clk);
        req_i = v;
        @(negedge clk);
        m_raw = v;
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] d;
        rd(8'h00, 2'b10, d); chk({ctx, " R1 raw"}, d, m_raw);
        rd(8'h04, 2'b10, d); chk({ctx, " R2 fast status"}, d, m_raw & m_fm);
        rd(8'h08, 2'b10, d); chk({ctx, " R2 norm status"}, d, m_raw & m_nm);
        rd(8'h0C, 2'b10, d); chk({ctx, " R5 fast mask"}, d, m_fm);
        rd(8'h10, 2'b10, d); chk({ctx, " R5 norm mask"}, d, m_nm);
        rd(8'h14, 2'b10, d); chk({ctx, " R6 clr read"}, d, 32'h0);
        rd(8'h18, 2'b10, d); chk({ctx, " R6 clr read"}, d, 32'h0);
        chk({ctx, " R3 fiq"}, {31'h0, fiq_o}, {31'h0, |(m_raw & m_fm)});
        chk({ctx, " R4 irq"}, {31'h0, irq_o}, {31'h0, |(m_raw & m_nm)});
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R9 reset state
        rst_n = 1'b1;
        check_all("reset R9");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][43:42] == 2'd0) drive_req(VEC[i][31:0]);
            else wr(VEC[i][39:32], VEC[i][41:40], VEC[i][31:0]);
            check_all($sformatf("vec%0d", i));
        end

        // R7 narrow reads of a nonzero mask return zero
        wr(8'h0C, 2'b10, 32'h0000_FFFF);
        rd(8'h0C, 2'b00, d); chk("R7 byte read", d, 32'h0);
        rd(8'h0C, 2'b01, d); chk("R7 half read", d, 32'h0);
        // R8 misaligned and unlisted offsets read zero
        rd(8'h0E, 2'b10, d); chk("R8 misaligned read", d, 32'h0);
        rd(8'h1C, 2'b10, d); chk("R8 unlisted read", d, 32'h0);
        // R10 idle bus reads zero and ignores write strobes
        #1 chk("R10 idle rdata", bus_rdata, 32'h0);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_we = 1'b0;
        check_all("R10 idle write");

        // R9 reset mid-run clears everything
        drive_req(32'hFFFF_FFFF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; req_i = '0;
        m_raw = '0; m_fm = '0; m_nm = '0;
        chk("R9 fiq after reset", {31'h0, fiq_o}, 32'h0);
        chk("R9 irq after reset", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        check_all("R9 post reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule